// File: doc/BRIEF.md
# Four-Channel Complementary Audio PWM Modulator

The block converts four streams of signed audio samples into pulse-width-modulated pin pairs, one pair per channel, meant to feed external Class-D power stages. Each channel has an A pin and a B pin. While the channel is active, B is the inverse of A. The carrier period is a fixed number of clock cycles. At the default of 128 cycles, a 49.152 MHz clock gives a 384 kHz carrier. A is high for the first part of each period, and the length of that high time follows the sample that was latched when the period began.

The high time is kept a few cycles away from both ends of the period. At full scale the split is about 97:3, so neither pin stays at one level for a whole period. A soft-start sequencer ramps every channel from a 50% idle duty toward its sample value over a fixed number of periods after the enable input rises. On disable it ramps back to 50% before it parks both pins low. A ready output is high only while the modulator runs at full depth, so a downstream power stage can stay muted through both ramps.

Top module: `cdpwm_modulator`

## Requirements
- R1: There are four channels. While the modulator is active, each channel's B pin equals the inverse of its A pin in every cycle, so A and B are never high together.
- R2: The carrier period is 128 cycles. A is high for the first h cycles of each period and low for the rest, where h = 64 + floor(s / 512) and s is the 16-bit two's-complement sample of that channel. A zero sample therefore gives h = 64 (50%).
- R3: h is limited to the range 4..124. Sample 0x7FFF gives 124 high cycles, sample 0x8000 gives 4, and both pins toggle in every active period.
- R4: A channel takes its sample only at the start of a carrier period. A sample change in the middle of a period leaves that period's high time unchanged and is applied from the next period.
- R5: When enable rises, the first active period has h = 64 on every channel. Periods then follow with ramp step k = 1..8, and period k has h = 64 + floor((hc - 64) * k / 8), where hc is the limited value from R2/R3. From step 8 on, the channel uses hc.
- R6: Ready stays low through the whole ramp-up. It rises between 8*128 and 9*128+2 cycles after enable rises, and it is high only while running at full depth.
- R7: When enable falls, ready is low within two clock cycles. The pins keep modulating while the duty ramps back, and within 11 periods both pins of every channel are low and stay low.
- R8: While reset (active low) is asserted, all A and B pins and ready are low.
- R9: While the modulator is off, all A and B pins stay low whatever the sample inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Power-up request; low requests power-down |
| sample_i | input | 64 | Four 16-bit signed samples, channel c in bits [16c+15:16c] |
| pwm_a_o | output | 4 | A pin of each channel |
| pwm_b_o | output | 4 | B pin of each channel, complement of A while active |
| ready_o | output | 1 | High when outputs are valid at full modulation depth |

## Verification
The period counter, a channel's latched duty, the ramp step and the sequencer phase can each go wrong, and each shows up at the pins within one or two carrier periods. A bad duty or ramp step changes the number of A-high cycles measured over a period that is aligned to A's rising edge. A bad phase either leaves the pins low when they should modulate or keeps them modulating after the ramp-down. Ready errors show up within a cycle of enable changing, or at the boundary of the ninth period. A duty that changes mid-period alters the measured count of the period already in progress.

// File: rtl/cdpwm_pkg.sv
package cdpwm_pkg;

  typedef enum logic [1:0] {
    PH_OFF = 2'd0,
    PH_UP  = 2'd1,
    PH_RUN = 2'd2,
    PH_DN  = 2'd3
  } cdpwm_phase_e;

  // High-time count for one period: scale, limit, then apply ramp step.
  function automatic int cdpwm_high(input int samp, input int shift,
                                    input int half, input int hmin,
                                    input int step, input int log_steps);
    int raw;
    int lim;
    raw = half + (samp >>> shift);
    lim = raw;
    if (lim < hmin)            lim = hmin;
    if (lim > 2 * half - hmin) lim = 2 * half - hmin;
    return half + (((lim - half) * step) >>> log_steps);
  endfunction

endpackage

// File: rtl/cdpwm_carrier.sv
module cdpwm_carrier #(
  parameter int PERIOD = 128,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = (cnt_q == CW'(PERIOD - 1));
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/cdpwm_sequencer.sv
module cdpwm_sequencer
  import cdpwm_pkg::*;
#(
  parameter int STEPS = 8,
  localparam int KW = $clog2(STEPS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          wrap_i,
  output cdpwm_phase_e  phase_o,
  output logic [KW-1:0] step_nxt_o,
  output logic          ready_o
);
  cdpwm_phase_e  phase_q, phase_n;
  logic [KW-1:0] step_q, step_n;
  logic          ready_q;

  always_comb begin
    phase_n = phase_q;
    step_n  = step_q;
    if (wrap_i) begin
      unique case (phase_q)
        PH_OFF: begin
          step_n = '0;
          if (enable_i) phase_n = PH_UP;
        end
        PH_UP: begin
          if (!enable_i) phase_n = PH_DN;
          else if (step_q == KW'(STEPS - 1)) begin
            step_n  = KW'(STEPS);
            phase_n = PH_RUN;
          end else step_n = step_q + 1'b1;
        end
        PH_RUN: if (!enable_i) phase_n = PH_DN;
        PH_DN: begin
          if (step_q == '0) phase_n = PH_OFF;
          else              step_n  = step_q - 1'b1;
        end
        default: phase_n = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OFF;
      step_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      phase_q <= phase_n;
      step_q  <= step_n;
      ready_q <= (phase_q == PH_RUN) && enable_i;
    end
  end

  assign phase_o    = phase_q;
  assign step_nxt_o = step_n;
  assign ready_o    = ready_q;
endmodule

// File: rtl/cdpwm_channel.sv
module cdpwm_channel
  import cdpwm_pkg::*;
#(
  parameter int SW = 16,
  parameter int PERIOD = 128,
  parameter int HMIN = 4,
  parameter int STEPS = 8,
  localparam int CW = $clog2(PERIOD),
  localparam int HW = CW + 1,
  localparam int KW = $clog2(STEPS + 1),
  localparam int HALF = PERIOD / 2,
  localparam int SHIFT = SW - $clog2(HALF) - 1,
  localparam int LOGST = $clog2(STEPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wrap_i,
  input  logic          on_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [SW-1:0] sample_i,
  input  logic [KW-1:0] step_nxt_i,
  output logic [HW-1:0] high_o,
  output logic          pwm_a_o,
  output logic          pwm_b_o
);
  logic [HW-1:0] high_q;
  logic [HW-1:0] high_n;

  always_comb
    high_n = HW'(cdpwm_high(int'($signed(sample_i)), SHIFT, HALF, HMIN,
                            int'(step_nxt_i), LOGST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     high_q <= HW'(HALF);
    else if (wrap_i) high_q <= high_n;
  end

  assign pwm_a_o = on_i && ({1'b0, cnt_i} < high_q);
  assign pwm_b_o = on_i && !pwm_a_o;
  assign high_o  = high_q;
endmodule

// File: rtl/cdpwm_modulator.sv
module cdpwm_modulator
  import cdpwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int SW = 16,
  parameter int PERIOD = 128,
  parameter int HMIN = 4,
  parameter int STEPS = 8,
  localparam int CW = $clog2(PERIOD),
  localparam int HW = CW + 1,
  localparam int KW = $clog2(STEPS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [NCH*SW-1:0] sample_i,
  output logic [NCH-1:0]   pwm_a_o,
  output logic [NCH-1:0]   pwm_b_o,
  output logic             ready_o
);
  logic [CW-1:0]     carrier_cnt;
  logic              carrier_wrap;
  cdpwm_phase_e      seq_phase;
  logic [KW-1:0]     seq_step_nxt;
  logic              mod_on;
  logic [NCH*HW-1:0] duty_all;

  cdpwm_carrier #(.PERIOD(PERIOD)) u_carrier (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (carrier_cnt),
    .wrap_o(carrier_wrap)
  );

  cdpwm_sequencer #(.STEPS(STEPS)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .wrap_i    (carrier_wrap),
    .phase_o   (seq_phase),
    .step_nxt_o(seq_step_nxt),
    .ready_o   (ready_o)
  );

  assign mod_on = (seq_phase != PH_OFF);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cdpwm_channel #(
      .SW(SW), .PERIOD(PERIOD), .HMIN(HMIN), .STEPS(STEPS)
    ) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wrap_i    (carrier_wrap),
      .on_i      (mod_on),
      .cnt_i     (carrier_cnt),
      .sample_i  (sample_i[c*SW +: SW]),
      .step_nxt_i(seq_step_nxt),
      .high_o    (duty_all[c*HW +: HW]),
      .pwm_a_o   (pwm_a_o[c]),
      .pwm_b_o   (pwm_b_o[c])
    );
  end
endmodule

// File: rtl/cdpwm_checker.sv
module cdpwm_checker
  import cdpwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int HW = 8,
  parameter int PERIOD = 128,
  parameter int HMIN = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              ready_o,
  input logic [NCH-1:0]    pwm_a_o,
  input logic [NCH-1:0]    pwm_b_o,
  input logic              carrier_wrap,
  input cdpwm_phase_e      seq_phase,
  input logic [NCH*HW-1:0] duty_all
);
  assert_no_overlap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_a_o & pwm_b_o) == '0);

  assert_pair_active_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_phase != PH_OFF) |-> ((pwm_a_o ^ pwm_b_o) == '1));

  assert_ready_in_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (seq_phase == PH_RUN));

  assert_ready_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !ready_o);

  assert_off_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_phase == PH_OFF) |-> ((pwm_a_o | pwm_b_o) == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_duty_span_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(duty_all[c*HW +: HW]) >= HMIN) &&
      (int'(duty_all[c*HW +: HW]) <= PERIOD - HMIN));

    assert_latch_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !carrier_wrap |=> $stable(duty_all[c*HW +: HW]));
  end
endmodule

bind cdpwm_modulator cdpwm_checker #(
  .NCH(NCH), .HW(HW), .PERIOD(PERIOD), .HMIN(HMIN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .ready_o     (ready_o),
  .pwm_a_o     (pwm_a_o),
  .pwm_b_o     (pwm_b_o),
  .carrier_wrap(carrier_wrap),
  .seq_phase   (seq_phase),
  .duty_all    (duty_all)
);

// File: tb/cdpwm_modulator_tb.sv
module cdpwm_modulator_tb;
  localparam int NCH = 4;
  localparam int SW  = 16;
  localparam int PER = 128;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              enable_i = 1'b0;
  logic [NCH*SW-1:0] sample_i = '0;
  logic [NCH-1:0]    pwm_a_o, pwm_b_o;
  logic              ready_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit pair_bad;
  bit ready_seen;

  cdpwm_modulator u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i),
    .sample_i(sample_i), .pwm_a_o(pwm_a_o), .pwm_b_o(pwm_b_o), .ready_o(ready_o)
  );

  always #4 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got cycle %0d exp below 150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  function automatic int fdiv(input int p, input int d);
    int q;
    q = p / d;
    if ((p % d != 0) && (p < 0)) q = q - 1;
    return q;
  endfunction

  function automatic int ref_high(input int s, input int k);
    int h;
    h = 64 + fdiv(s, 512);
    if (h < 4) h = 4;
    if (h > 124) h = 124;
    return 64 + fdiv((h - 64) * k, 8);
  endfunction

  task automatic check(input bit ok, input string req, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d exp %0d", req, got, exp);
    end
  endtask

  function automatic int samp(input int c);
    return int'($signed(sample_i[c*SW +: SW]));
  endfunction

  // Pair check on each negedge sample while modulating.
  task automatic pair_look();
    if (pwm_b_o !== ~pwm_a_o) pair_bad = 1'b1;
    if (ready_o) ready_seen = 1'b1;
  endtask

  task automatic sync_rise(input int c, output bit ok);
    bit prev;
    ok = 1'b0;
    @(negedge clk_i); prev = pwm_a_o[c];
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_i);
      if (pwm_a_o[c] && !prev) begin ok = 1'b1; break; end
      prev = pwm_a_o[c];
    end
  endtask

  // Count A-high cycles over one period; first sample may already be taken.
  task automatic period_high(input int c, input bit first, output int hc);
    hc = first ? 1 : 0;
    if (first) pair_look();
    for (int i = 0; i < (first ? PER - 1 : PER); i++) begin
      @(negedge clk_i);
      pair_look();
      if (pwm_a_o[c]) hc++;
    end
  endtask

  task automatic measure(input int c, input string req);
    bit ok;
    int hc;
    sync_rise(c, ok);
    check(ok, req, int'(ok), 1);
    period_high(c, 1'b1, hc);
    check(hc == ref_high(samp(c), 8), req, hc, ref_high(samp(c), 8));
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    bit ok;
    int hc;
    int exp;
    int t;
    bit quiet;
    int corners[7];
    void'($urandom(32'd1234));
    corners = '{32'h7FFF, -32768, 0, -1, 512, -512, 32'h4321};

    for (int c = 0; c < NCH; c++) sample_i[c*SW +: SW] = SW'($urandom);
    wait_cyc(3);
    check(pwm_a_o == '0 && pwm_b_o == '0 && ready_o == 1'b0, "R8 reset",
          int'({pwm_a_o, pwm_b_o, ready_o}), 0);
    rst_ni = 1'b1;

    // R9: off state ignores samples
    quiet = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      if (i % 50 == 0) sample_i = {$urandom, $urandom};
      if (pwm_a_o != '0 || pwm_b_o != '0 || ready_o) quiet = 1'b0;
    end
    check(quiet, "R9 off quiet", int'(quiet), 1);

    // R5/R6: ramp-up profile on channel 0 at full scale
    sample_i[0 +: SW] = 16'h7FFF;
    sample_i[SW +: SW] = 16'hA000;
    @(negedge clk_i); enable_i = 1'b1;
    sync_rise(0, ok);
    check(ok, "R5 start", int'(ok), 1);
    ready_seen = 1'b0;
    pair_bad = 1'b0;
    for (int k = 0; k <= 8; k++) begin
      period_high(0, k == 0, hc);
      exp = ref_high(32767, k);
      check(hc == exp, $sformatf("R5 step %0d", k), hc, exp);
      if (k == 7) check(!ready_seen, "R6 low in ramp", int'(ready_seen), 0);
    end
    check(ready_o == 1'b1, "R6 ready after ramp", int'(ready_o), 1);
    check(!pair_bad, "R1 complement", int'(pair_bad), 0);

    // R2/R3: directed corners on every channel
    for (int j = 0; j < 7; j++) begin
      for (int c = 0; c < NCH; c++) sample_i[c*SW +: SW] = SW'(corners[(j + c) % 7]);
      wait_cyc(2 * PER);
      for (int c = 0; c < NCH; c++)
        measure(c, (corners[(j + c) % 7] == 32767 || corners[(j + c) % 7] == -32768)
                   ? "R3 full scale" : "R2 corner");
    end

    // R2: random samples
    for (int r = 0; r < 8; r++) begin
      sample_i = {$urandom, $urandom};
      wait_cyc(2 * PER);
      for (int c = 0; c < NCH; c++) measure(c, "R2 random");
    end

    // R1 complement over all of the above
    check(!pair_bad, "R1 complement", int'(pair_bad), 0);

    // R4: mid-period change applies at the next period
    sample_i[2*SW +: SW] = 16'h6000;
    wait_cyc(2 * PER);
    sync_rise(2, ok);
    hc = 1;
    for (int i = 1; i < PER; i++) begin
      @(negedge clk_i);
      if (i == 40) sample_i[2*SW +: SW] = 16'hB000;
      if (pwm_a_o[2]) hc++;
    end
    exp = ref_high(32'h6000, 8);
    check(hc == exp, "R4 mid-period hold", hc, exp);
    period_high(2, 1'b0, hc);
    exp = ref_high(-20480, 8);
    check(hc == exp, "R4 next period", hc, exp);

    // R7: power-down
    sample_i[0 +: SW] = 16'h7FFF;
    wait_cyc(2 * PER + 17);
    enable_i = 1'b0;
    wait_cyc(2);
    check(ready_o == 1'b0, "R7 ready drop", int'(ready_o), 0);
    wait_cyc(2 * PER);
    sync_rise(0, ok);
    check(ok, "R7 still modulating", int'(ok), 1);
    wait_cyc(11 * PER);
    quiet = 1'b1;
    for (int i = 0; i < 2 * PER; i++) begin
      @(negedge clk_i);
      if (pwm_a_o != '0 || pwm_b_o != '0 || ready_o) quiet = 1'b0;
    end
    check(quiet, "R7 parked low", int'(quiet), 1);

    // R6: ready latency on re-enable
    enable_i = 1'b1;
    t = 0;
    while (!ready_o && t < 12 * PER) begin @(negedge clk_i); t++; end
    check(t >= 8 * PER && t <= 9 * PER + 2, "R6 ready latency", t, 9 * PER);

    // R8: reset mid-run
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(pwm_a_o == '0 && pwm_b_o == '0 && ready_o == 1'b0, "R8 reset in run",
          int'({pwm_a_o, pwm_b_o, ready_o}), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule